// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out subroutine call and return for a 32-bit processor core. It is driven by one of three start pulses: a call through a register, a call to an absolute address, or a return. It then walks through a fixed series of word accesses on a single memory port, one at a time, each held until the memory accepts it. When the last access completes it commits new frame pointer, stack pointer and program counter values together, and raises `done_o` for one cycle. The core's register file reads these values on that pulse.

Every call frame holds three words. From the higher address down they are a spare static-chain word, the return address, and the caller's frame pointer. The new frame pointer and the new stack pointer both point at the saved frame pointer word. A return does not pop a mirror image of the call. It rebuilds the stack pointer from the frame pointer, reloads the saved frame pointer and the return address, and then steps over the static-chain word.

States and transitions:
- `SQ_IDLE` goes to `SQ_PUSH_LINK` on a call start, or to `SQ_POP_FP` on a return start.
- `SQ_PUSH_LINK` stores the return address and goes to `SQ_PUSH_FP` when the memory signals ready.
- `SQ_PUSH_FP` stores the old frame pointer and goes back to `SQ_IDLE` on ready. This is a commit.
- `SQ_POP_FP` loads the saved frame pointer and goes to `SQ_POP_LINK` on ready.
- `SQ_POP_LINK` loads the return address and goes back to `SQ_IDLE` on ready. This is a commit.

Top module: `frame_seq`

## Requirements
- R1: A register-indirect call stores the return address PC+2 at address SP-8, then stores the incoming FP at SP-12, in that order. Both are writes (`mem_we_o`=1).
- R2: An absolute call stores the return address PC+6, and its new PC is the literal input rather than the target register input.
- R3: A call commits FP = SP-12, SP = SP-12 and PC = the call destination.
- R4: A return reads address FP first, then FP+4 (`mem_we_o`=0). It commits FP = the first word read, PC = the second word read, and SP = FP+12.
- R5: Exactly one request is outstanding while busy. Address, write flag and write data hold steady until `mem_ready_i` is seen high at a clock edge, and the next access starts only after that edge.
- R6: `done_o` is high for exactly the one cycle after the final access handshake. `fp_o`, `sp_o` and `pc_o` change only in that cycle.
- R7: A start pulse that arrives while busy is ignored. This includes the cycle in which the final handshake takes place.
- R8: When several starts arrive together, the register-indirect call wins over the absolute call, and the absolute call wins over the return.
- R9: The two low bits of every memory address are zero. Writeback values keep their full arithmetic value.
- R10: After reset the block is idle with no request, no done, and `fp_o`, `sp_o` and `pc_o` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_reg_i | input | 1 | Start pulse: call to the address held in a register |
| call_abs_i | input | 1 | Start pulse: call to an absolute literal address |
| ret_i | input | 1 | Start pulse: return |
| pc_i | input | 32 | PC of the calling instruction |
| target_i | input | 32 | Register value used as destination of a register-indirect call |
| literal_i | input | 32 | 32-bit literal used as destination of an absolute call |
| fp_i | input | 32 | Current frame pointer |
| sp_i | input | 32 | Current stack pointer |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Store data |
| mem_ready_i | input | 1 | Memory accepts the request; load data valid in the same cycle |
| mem_rdata_i | input | 32 | Load data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle commit pulse |
| fp_o | output | 32 | Committed frame pointer |
| sp_o | output | 32 | Committed stack pointer |
| pc_o | output | 32 | Committed program counter |

## Verification
Two events can land in the same clock edge: the final memory handshake of one sequence and a new start pulse. The bench raises a start in exactly the cycle it grants ready to the last access, and its model expects that start to be dropped. It then raises another start in the `done_o` cycle, which the model expects to be accepted at once. A reference model compares every request field, the done pulse and the three writeback values on every clock, while ready latency varies from zero to several cycles.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE      = 3'd0,
        SQ_PUSH_LINK = 3'd1,
        SQ_PUSH_FP   = 3'd2,
        SQ_POP_FP    = 3'd3,
        SQ_POP_LINK  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/frame_seq_fsm.sv
module frame_seq_fsm
    import frame_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_call_reg,
    input  logic       go_call_abs,
    input  logic       go_ret,
    input  logic       hs,
    output seq_state_t state_o,
    output logic       take_reg,
    output logic       take_abs,
    output logic       take_ret,
    output logic       finish
);

    seq_state_t state_q, state_d;
    logic       idle;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (go_call_reg || go_call_abs) state_d = SQ_PUSH_LINK;
                else if (go_ret)                state_d = SQ_POP_FP;
            end
            SQ_PUSH_LINK: if (hs) state_d = SQ_PUSH_FP;
            SQ_PUSH_FP:   if (hs) state_d = SQ_IDLE;
            SQ_POP_FP:    if (hs) state_d = SQ_POP_LINK;
            SQ_POP_LINK:  if (hs) state_d = SQ_IDLE;
            default:      state_d = SQ_IDLE;
        endcase
    end

    // decoded outputs
    always_comb begin
        idle     = (state_q == SQ_IDLE);
        take_reg = idle && go_call_reg;
        take_abs = idle && !go_call_reg && go_call_abs;
        take_ret = idle && !go_call_reg && !go_call_abs && go_ret;
        finish   = hs && ((state_q == SQ_PUSH_FP) || (state_q == SQ_POP_LINK));
        state_o  = state_q;
    end

endmodule

// File: rtl/frame_seq_path.sv
module frame_seq_path
    import frame_seq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4,
    parameter int SHORT_LEN  = 2,
    parameter int LONG_LEN   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_t      state,
    input  logic            take_reg,
    input  logic            take_abs,
    input  logic            take_ret,
    input  logic            hs,
    input  logic            finish,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] target_i,
    input  logic [XLEN-1:0] literal_i,
    input  logic [XLEN-1:0] fp_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] rdata_i,
    output logic [XLEN-1:0] addr_o,
    output logic [XLEN-1:0] wdata_o,
    output logic [XLEN-1:0] fp_o,
    output logic [XLEN-1:0] sp_o,
    output logic [XLEN-1:0] pc_o,
    output logic            done_o
);

    localparam logic [XLEN-1:0] WORD_V  = XLEN'(WORD_BYTES);
    localparam logic [XLEN-1:0] LINK_V  = XLEN'(2 * WORD_BYTES);
    localparam logic [XLEN-1:0] FRAME_V = XLEN'(3 * WORD_BYTES);
    localparam logic [XLEN-1:0] MASK_V  = ~(XLEN'(WORD_BYTES - 1));
    localparam logic [XLEN-1:0] SHORT_V = XLEN'(SHORT_LEN);
    localparam logic [XLEN-1:0] LONG_V  = XLEN'(LONG_LEN);

    logic [XLEN-1:0] sp_q, fp_q, link_q, dest_q, popfp_q;
    logic [XLEN-1:0] raw_addr;

    // operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= '0;
            fp_q    <= '0;
            link_q  <= '0;
            dest_q  <= '0;
            popfp_q <= '0;
        end else begin
            if (take_reg || take_abs) begin
                sp_q   <= sp_i;
                fp_q   <= fp_i;
                link_q <= pc_i + (take_reg ? SHORT_V : LONG_V);
                dest_q <= take_reg ? target_i : literal_i;
            end else if (take_ret) begin
                fp_q <= fp_i;
            end
            if (state == SQ_POP_FP && hs) popfp_q <= rdata_i;
        end
    end

    // commit of the writeback values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_o   <= '0;
            sp_o   <= '0;
            pc_o   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= finish;
            if (finish) begin
                if (state == SQ_PUSH_FP) begin
                    fp_o <= sp_q - FRAME_V;
                    sp_o <= sp_q - FRAME_V;
                    pc_o <= dest_q;
                end else begin
                    fp_o <= popfp_q;
                    sp_o <= fp_q + FRAME_V;
                    pc_o <= rdata_i;
                end
            end
        end
    end

    // request fields
    always_comb begin
        raw_addr = '0;
        wdata_o  = '0;
        unique case (state)
            SQ_PUSH_LINK: begin raw_addr = sp_q - LINK_V;  wdata_o = link_q; end
            SQ_PUSH_FP:   begin raw_addr = sp_q - FRAME_V; wdata_o = fp_q;   end
            SQ_POP_FP:    raw_addr = fp_q;
            SQ_POP_LINK:  raw_addr = fp_q + WORD_V;
            default:      raw_addr = '0;
        endcase
        addr_o = raw_addr & MASK_V;
    end

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4,
    parameter int SHORT_LEN  = 2,
    parameter int LONG_LEN   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_reg_i,
    input  logic            call_abs_i,
    input  logic            ret_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] target_i,
    input  logic [XLEN-1:0] literal_i,
    input  logic [XLEN-1:0] fp_i,
    input  logic [XLEN-1:0] sp_i,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    input  logic            mem_ready_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] fp_o,
    output logic [XLEN-1:0] sp_o,
    output logic [XLEN-1:0] pc_o
);

    seq_state_t state;
    logic take_reg, take_abs, take_ret, finish, hs;

    always_comb begin
        mem_req_o = (state != SQ_IDLE);
        mem_we_o  = (state == SQ_PUSH_LINK) || (state == SQ_PUSH_FP);
        busy_o    = mem_req_o;
        hs        = mem_req_o && mem_ready_i;
    end

    frame_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_call_reg (call_reg_i),
        .go_call_abs (call_abs_i),
        .go_ret      (ret_i),
        .hs          (hs),
        .state_o     (state),
        .take_reg    (take_reg),
        .take_abs    (take_abs),
        .take_ret    (take_ret),
        .finish      (finish)
    );

    frame_seq_path #(
        .XLEN       (XLEN),
        .WORD_BYTES (WORD_BYTES),
        .SHORT_LEN  (SHORT_LEN),
        .LONG_LEN   (LONG_LEN)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .take_reg  (take_reg),
        .take_abs  (take_abs),
        .take_ret  (take_ret),
        .hs        (hs),
        .finish    (finish),
        .pc_i      (pc_i),
        .target_i  (target_i),
        .literal_i (literal_i),
        .fp_i      (fp_i),
        .sp_i      (sp_i),
        .rdata_i   (mem_rdata_i),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_wdata_o),
        .fp_o      (fp_o),
        .sp_o      (sp_o),
        .pc_o      (pc_o),
        .done_o    (done_o)
    );

endmodule

// File: rtl/frame_seq_checker.sv
module frame_seq_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req_o,
    input logic            mem_we_o,
    input logic [XLEN-1:0] mem_addr_o,
    input logic [XLEN-1:0] mem_wdata_o,
    input logic            mem_ready_i,
    input logic            done_o,
    input logic [XLEN-1:0] fp_o,
    input logic [XLEN-1:0] sp_o,
    input logic [XLEN-1:0] pc_o
);

    // R5: a waiting request keeps its fields
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                         && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R6: done is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done follows a handshake
    assert_done_after_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_req_o && mem_ready_i));

    // R6: writeback values move only with done
    assert_wb_only_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(fp_o) && $stable(sp_o) && $stable(pc_o)));

    // R9: addresses are word aligned
    assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    // R1: a completed store is followed by a second store or the commit
    assert_store_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ready_i) |=> ((mem_req_o && mem_we_o) || done_o));

endmodule

bind frame_seq frame_seq_checker #(.XLEN(XLEN)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .done_o      (done_o),
    .fp_o        (fp_o),
    .sp_o        (sp_o),
    .pc_o        (pc_o)
);

// File: tb/frame_seq_bench.sv
module frame_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_reg_i = 1'b0, call_abs_i = 1'b0, ret_i = 1'b0;
    logic [31:0] pc_i = '0, target_i = '0, literal_i = '0, fp_i = '0, sp_i = '0;
    logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0, busy_o, done_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0, fp_o, sp_o, pc_o;

    always #2.5 clk = ~clk;

    frame_seq u_frame_seq (
        .clk(clk), .rst_n(rst_n),
        .call_reg_i(call_reg_i), .call_abs_i(call_abs_i), .ret_i(ret_i),
        .pc_i(pc_i), .target_i(target_i), .literal_i(literal_i),
        .fp_i(fp_i), .sp_i(sp_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fp_o(fp_o), .sp_o(sp_o), .pc_o(pc_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } acc_t;

    acc_t        q[$];
    logic [31:0] mem [int unsigned];
    string       tag = "R10";
    bit          wb_pending = 0, m_done = 0;
    logic [31:0] p_fp = '0, p_sp = '0, p_pc = '0;
    logic [31:0] m_fp = '0, m_sp = '0, m_pc = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'hC0DE_0000;
    endfunction

    function automatic acc_t mk(input logic we, input logic [31:0] a, input logic [31:0] d);
        acc_t x;
        x.we = we; x.addr = a & 32'hFFFF_FFFC; x.data = d;
        return x;
    endfunction

    // kind bits: 0 reg call, 1 abs call, 2 return
    task automatic cyc(input bit rdy, input int kind);
        bit busy_before;
        @(negedge clk);
        if (wb_pending) begin
            m_done = 1; m_fp = p_fp; m_sp = p_sp; m_pc = p_pc; wb_pending = 0;
        end else begin
            m_done = 0;
        end
        // per-clock comparison against the model
        chk(mem_req_o == (q.size() != 0), "R5", "req", 32'(mem_req_o), 32'(q.size() != 0));
        chk(busy_o == (q.size() != 0), "R7", "busy", 32'(busy_o), 32'(q.size() != 0));
        if (q.size() != 0 && mem_req_o) begin
            chk(mem_addr_o == q[0].addr, tag, "addr", mem_addr_o, q[0].addr);
            chk(mem_addr_o[1:0] == 2'b00, "R9", "align", mem_addr_o, q[0].addr);
            chk(mem_we_o == q[0].we, tag, "we", 32'(mem_we_o), 32'(q[0].we));
            if (q[0].we) chk(mem_wdata_o == q[0].data, tag, "wdata", mem_wdata_o, q[0].data);
        end
        chk(done_o == m_done, "R6", "done", 32'(done_o), 32'(m_done));
        chk(fp_o == m_fp, tag, "fp_o", fp_o, m_fp);
        chk(sp_o == m_sp, tag, "sp_o", sp_o, m_sp);
        chk(pc_o == m_pc, tag, "pc_o", pc_o, m_pc);
        // drive next cycle
        busy_before = (q.size() != 0);
        mem_ready_i = rdy;
        mem_rdata_i = (busy_before && !q[0].we) ? rd(q[0].addr) : 32'h0;
        if (busy_before && rdy) begin
            if (q[0].we) mem[q[0].addr] = q[0].data;
            void'(q.pop_front());
            if (q.size() == 0) wb_pending = 1;
        end
        call_reg_i = kind[0];
        call_abs_i = kind[1];
        ret_i      = kind[2];
        if (!busy_before && kind != 0) begin
            if (kind[0] || kind[1]) begin
                logic [31:0] ra;
                ra  = pc_i + (kind[0] ? 32'd2 : 32'd6);
                tag = kind[0] ? ((kind[1] || kind[2]) ? "R8" : "R1") : "R2";
                q.push_back(mk(1'b1, sp_i - 32'd8, ra));
                q.push_back(mk(1'b1, sp_i - 32'd12, fp_i));
                p_fp = sp_i - 32'd12;
                p_sp = sp_i - 32'd12;
                p_pc = kind[0] ? target_i : literal_i;
            end else begin
                tag = "R4";
                q.push_back(mk(1'b0, fp_i, 32'h0));
                q.push_back(mk(1'b0, fp_i + 32'd4, 32'h0));
                p_fp = rd(fp_i & 32'hFFFF_FFFC);
                p_pc = rd((fp_i + 32'd4) & 32'hFFFF_FFFC);
                p_sp = fp_i + 32'd12;
            end
        end
    endtask

    task automatic drain(input int lat);
        for (int k = 0; k < 60; k++) begin
            cyc(((k % (lat + 1)) == lat), 0);
            if (q.size() == 0 && !wb_pending && !m_done) break;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        cyc(0, 0);

        // R1 / R3: register-indirect call, no wait
        pc_i = 32'h0000_0100; target_i = 32'h0000_2000; literal_i = 32'h0000_9990;
        sp_i = 32'h0000_8000; fp_i = 32'h0000_8100;
        cyc(0, 1);
        drain(0);

        // R2 / R3: absolute call with wait states
        pc_i = 32'h0000_0200; literal_i = 32'h0000_3000;
        sp_i = 32'h0000_7FF4; fp_i = 32'h0000_7FF4;
        cyc(0, 2);
        drain(2);

        // R4: return from the frame just built
        fp_i = 32'h0000_7FE8; sp_i = 32'h0000_7F00;
        cyc(0, 4);
        drain(1);

        // R7: start pulses while busy are ignored
        pc_i = 32'h0000_0400; target_i = 32'h0000_4000;
        sp_i = 32'h0000_6000; fp_i = 32'h0000_6100;
        cyc(0, 1);
        cyc(0, 4);
        cyc(0, 2);
        cyc(1, 4);
        cyc(0, 1);
        drain(0);

        // R7: start in the cycle of the final handshake is dropped, start in the done cycle taken
        fp_i = 32'h0000_5FF4;
        cyc(0, 4);
        cyc(1, 0);
        cyc(0, 0);
        cyc(1, 1);
        cyc(0, 4);
        drain(1);

        // R8: all three at once, register call wins
        pc_i = 32'h0000_0600; target_i = 32'h0000_A000; literal_i = 32'h0000_B000;
        sp_i = 32'h0000_5000; fp_i = 32'h0000_5100;
        cyc(0, 7);
        drain(0);
        // R8: absolute call wins over return
        pc_i = 32'h0000_0700; sp_i = 32'h0000_4800;
        cyc(0, 6);
        drain(0);

        // R9: unaligned pointers give aligned addresses, full-value writeback
        pc_i = 32'h0000_0800; target_i = 32'h0000_C000;
        sp_i = 32'h0000_4403; fp_i = 32'h0000_4501;
        cyc(0, 1);
        drain(1);
        fp_i = 32'h0000_43F6;
        cyc(0, 4);
        drain(0);

        cyc(0, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule